// File: doc/BRIEF.md
# Dual-Port Banked Shared Buffer

This block is a shared scratch memory split into two banks of 1024 bytes. A host bus and the card's processor bus can both reach it. Each bank belongs to exactly one of the two sides at any moment. While the host works in one bank, the processor can work in the other in the same clock cycle, and neither disturbs the other. Ownership is handed over per bank through a small control port. A typical use is a ping-pong exchange: one side fills a bank, then hands it to the other side and moves on to the second bank.

The processor port is always a 16-bit port with two byte enables. The host port runs in one of three modes. In word mode it moves 16-bit words. In byte mode it moves single bytes on a chosen lane. When disabled, the memory cannot be reached from the host at all. A chip select from upstream address decoding qualifies every access. Read data appears one clock after the access. An access to a bank that the other side owns has no effect on memory and reads back all ones. Such an access also sets a sticky error flag. A request to change ownership never cuts into an access: if the bank is being addressed in that cycle, the change waits for the first cycle in which the bank is idle.

Top module: `shared_bank_buf`

## Requirements
- R1: During reset and on the first clock after it, errFlag is 0 and both read-data outputs are 0. ownState equals the RESET_OWNER parameter. By default bank 0 belongs to the host and bank 1 to the processor; an ownState bit of 0 means host and 1 means processor.
- R2: Address bit 10 selects the bank and bits 9:0 give the byte offset inside the bank. In word mode (hostMode = 2'b10), a host write stores hostWdata in the word that holds the addressed byte, and hostAddr[0] is ignored. A host read returns that word on hostRdata one clock later.
- R3: In byte mode (hostMode = 2'b01), hostAddr[0] picks the byte lane: an even address uses the low byte [7:0] and an odd address uses the high byte [15:8]. A write stores hostWdata[7:0] into that lane only. A read returns the addressed byte on hostRdata[7:0], with hostRdata[15:8] = 0.
- R4: cpuAddr is a word address made of bits 10:1. A processor write updates the low byte when cpuBe[0] is 1 and the high byte when cpuBe[1] is 1. A processor read returns the whole word on cpuRdata one clock later.
- R5: When the host and the processor address different banks that each of them owns, both accesses complete in the same cycle without affecting each other, and errFlag does not change.
- R6: An access to a bank owned by the other side leaves memory unchanged. A read of that kind returns 16'hFFFF, and the access sets errFlag.
- R7: errFlag stays set until errClr is asserted. If a new error occurs in the same cycle as errClr, the flag stays set.
- R8: When ownWr is 1, bank ownBank is given to ownVal (0 = host, 1 = processor). If neither port addresses that bank in that cycle, the change shows on ownState after that clock edge.
- R9: If either port addresses the bank in the cycle of the request, the access runs under the old owner and the change is held back. It takes effect at the first later edge at which the bank is not addressed.
- R10: With hostMode 2'b00 or 2'b11, the host port is disabled. Host writes leave memory unchanged, host reads return 16'hFFFF, and errFlag is not set.
- R11: When both ports address the same bank in one cycle, only the owner's access takes effect and errFlag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access request (decoded chip select) |
| hostWr | input | 1 | Host write (1) or read (0) |
| hostMode | input | 2 | 00 off, 01 byte, 10 word, 11 off |
| hostAddr | input | 11 | Host byte address, bit 10 = bank |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, one clock after the read |
| cpuSel | input | 1 | Processor access request |
| cpuWr | input | 1 | Processor write (1) or read (0) |
| cpuAddr | input | 10 | Processor word address, bits 10:1 |
| cpuBe | input | 2 | Processor byte enables, bit 0 = low byte |
| cpuWdata | input | 16 | Processor write data |
| cpuRdata | output | 16 | Processor read data, one clock after the read |
| ownWr | input | 1 | Ownership change request |
| ownBank | input | 1 | Bank addressed by the ownership request |
| ownVal | input | 1 | New owner, 0 host and 1 processor |
| errClr | input | 1 | Clears the sticky error flag |
| ownState | output | 2 | Current owner of each bank |
| errFlag | output | 1 | Sticky flag for refused accesses |

## Verification
A wrong ownership bit shows up on the very next clock: it appears on ownState at once, and a read from the bank that should have been reachable returns 16'hFFFF and raises errFlag. A lane-steering or byte-enable fault does not show up at the write. It shows only when the damaged word is read back, one clock after the read is issued. A deferral fault shows as an ownState change in the same cycle as an access to that bank, or as a change that never happens after the bank falls idle. A flag that fails to hold is seen as errFlag dropping without errClr.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    HM_OFF     = 2'b00,
    HM_BYTE    = 2'b01,
    HM_WORD    = 2'b10,
    HM_OFF_ALT = 2'b11
  } hostMode_e;

  // Per-bank memory strobe issued by the control
  typedef struct packed {
    logic             en;
    logic             fromHost;
    logic [LANES-1:0] we;
  } bankCmd_t;

  // Per-port read strobe issued by the control
  typedef struct packed {
    logic rd;
    logic forceOnes;
    logic byteMode;
    logic lane;
  } portCmd_t;

endpackage

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
  import sbb_pkg::*;
#(
  parameter int               NUM_BANKS   = 2,
  parameter int               BANK_BYTES  = 1024,
  parameter logic [NUM_BANKS-1:0] RESET_OWNER = 2'b10,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = OFF_W + BANK_W,
  localparam int WADR_W = OFF_W - 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 hostSel,
  input  logic                                 hostWr,
  input  logic [1:0]                           hostMode,
  input  logic [ADDR_W-1:0]                    hostAddr,
  input  logic                                 cpuSel,
  input  logic                                 cpuWr,
  input  logic [ADDR_W-1:1]                    cpuAddr,
  input  logic [LANES-1:0]                     cpuBe,
  input  logic                                 ownWr,
  input  logic [BANK_W-1:0]                    ownBank,
  input  logic                                 ownVal,
  input  logic                                 errClr,
  output bankCmd_t [NUM_BANKS-1:0]             bankCmd,
  output logic [NUM_BANKS-1:0][WADR_W-1:0]     bankAddr,
  output portCmd_t                             hostCmd,
  output logic [BANK_W-1:0]                    hostBankSel,
  output portCmd_t                             cpuCmd,
  output logic [BANK_W-1:0]                    cpuBankSel,
  output logic [NUM_BANKS-1:0]                 ownState,
  output logic                                 errFlag
);

  hostMode_e            modeE;
  logic                 hostOn, hostByte, hostLane;
  logic [BANK_W-1:0]    hostBank, cpuBank;
  logic [WADR_W-1:0]    hostWord, cpuWord;
  logic                 hostHit, hostOk, cpuOk;
  logic [LANES-1:0]     hostWe, cpuWe;
  logic [NUM_BANKS-1:0] ownQ, pendV, pendVal, touched;

  assign modeE    = hostMode_e'(hostMode);
  assign hostOn   = (modeE == HM_BYTE) || (modeE == HM_WORD);
  assign hostByte = (modeE == HM_BYTE);
  assign hostLane = hostAddr[0];
  assign hostBank = hostAddr[ADDR_W-1:OFF_W];
  assign hostWord = hostAddr[OFF_W-1:1];
  assign cpuBank  = cpuAddr[ADDR_W-1:OFF_W];
  assign cpuWord  = cpuAddr[OFF_W-1:1];

  assign hostHit  = hostSel && hostOn;
  assign hostOk   = hostHit && !ownQ[hostBank];
  assign cpuOk    = cpuSel && ownQ[cpuBank];

  always_comb begin
    if (!hostWr)       hostWe = '0;
    else if (hostByte) hostWe = {hostLane, !hostLane};
    else               hostWe = '1;
  end

  assign cpuWe = cpuWr ? cpuBe : '0;

  // Bank steering: the owner alone drives each bank
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bankCmd[b].fromHost = !ownQ[b];
      bankCmd[b].en       = ownQ[b] ? (cpuOk && cpuBank == BANK_W'(b))
                                    : (hostOk && hostBank == BANK_W'(b));
      bankCmd[b].we       = bankCmd[b].en ? (ownQ[b] ? cpuWe : hostWe) : '0;
      bankAddr[b]         = ownQ[b] ? cpuWord : hostWord;
      touched[b]          = (hostHit && hostBank == BANK_W'(b)) ||
                            (cpuSel && cpuBank == BANK_W'(b));
    end
  end

  // Ownership with deferral while a bank is being addressed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownQ    <= RESET_OWNER;
      pendV   <= '0;
      pendVal <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (ownWr && ownBank == BANK_W'(b)) begin
          if (touched[b]) begin
            pendV[b]   <= 1'b1;
            pendVal[b] <= ownVal;
          end else begin
            ownQ[b]  <= ownVal;
            pendV[b] <= 1'b0;
          end
        end else if (pendV[b] && !touched[b]) begin
          ownQ[b]  <= pendVal[b];
          pendV[b] <= 1'b0;
        end
      end
    end
  end

  // Sticky error: new error wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     errFlag <= 1'b0;
    else if ((hostHit && !hostOk) || (cpuSel && !cpuOk)) errFlag <= 1'b1;
    else if (errClr)                               errFlag <= 1'b0;
  end

  always_comb begin
    hostCmd.rd        = hostSel && !hostWr;
    hostCmd.forceOnes = !hostOk;
    hostCmd.byteMode  = hostByte;
    hostCmd.lane      = hostLane;
    cpuCmd.rd         = cpuSel && !cpuWr;
    cpuCmd.forceOnes  = !cpuOk;
    cpuCmd.byteMode   = 1'b0;
    cpuCmd.lane       = 1'b0;
  end

  assign hostBankSel = hostBank;
  assign cpuBankSel  = cpuBank;
  assign ownState    = ownQ;

endmodule

// File: rtl/sbb_datapath.sv
module sbb_datapath
  import sbb_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 1024,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int WADR_W = OFF_W - 1,
  localparam int WORDS  = BANK_BYTES / LANES
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  bankCmd_t [NUM_BANKS-1:0]         bankCmd,
  input  logic [NUM_BANKS-1:0][WADR_W-1:0] bankAddr,
  input  portCmd_t                         hostCmd,
  input  logic [BANK_W-1:0]                hostBankSel,
  input  portCmd_t                         cpuCmd,
  input  logic [BANK_W-1:0]                cpuBankSel,
  input  logic [WORD_W-1:0]                hostWdata,
  input  logic [WORD_W-1:0]                cpuWdata,
  output logic [WORD_W-1:0]                hostRdata,
  output logic [WORD_W-1:0]                cpuRdata
);

  logic [WORD_W-1:0] hostSteer;
  logic [NUM_BANKS-1:0][WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] hostWord, cpuWord;

  assign hostSteer = hostCmd.byteMode ? {LANES{hostWdata[LANE_W-1:0]}} : hostWdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] wrData;

    assign wrData = bankCmd[b].fromHost ? hostSteer : cpuWdata;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (bankCmd[b].en && bankCmd[b].we[l])
          mem[bankAddr[b]][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end

    assign rdWord[b] = mem[bankAddr[b]];
  end

  assign hostWord = rdWord[hostBankSel];
  assign cpuWord  = rdWord[cpuBankSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (hostCmd.rd) begin
      if (hostCmd.forceOnes)
        hostRdata <= '1;
      else if (hostCmd.byteMode)
        hostRdata <= {{(WORD_W-LANE_W){1'b0}},
                      hostWord[(hostCmd.lane ? LANE_W : 0) +: LANE_W]};
      else
        hostRdata <= hostWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdata <= '0;
    end else if (cpuCmd.rd) begin
      if (cpuCmd.forceOnes)
        cpuRdata <= '1;
      else if (cpuCmd.byteMode)
        cpuRdata <= {{(WORD_W-LANE_W){1'b0}},
                     cpuWord[(cpuCmd.lane ? LANE_W : 0) +: LANE_W]};
      else
        cpuRdata <= cpuWord;
    end
  end

endmodule

// File: rtl/shared_bank_buf.sv
module shared_bank_buf
  import sbb_pkg::*;
#(
  parameter int                   NUM_BANKS   = 2,
  parameter int                   BANK_BYTES  = 1024,
  parameter logic [NUM_BANKS-1:0] RESET_OWNER = 2'b10,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = OFF_W + BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostSel,
  input  logic                 hostWr,
  input  logic [1:0]           hostMode,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [WORD_W-1:0]    hostWdata,
  output logic [WORD_W-1:0]    hostRdata,
  input  logic                 cpuSel,
  input  logic                 cpuWr,
  input  logic [ADDR_W-1:1]    cpuAddr,
  input  logic [LANES-1:0]     cpuBe,
  input  logic [WORD_W-1:0]    cpuWdata,
  output logic [WORD_W-1:0]    cpuRdata,
  input  logic                 ownWr,
  input  logic [BANK_W-1:0]    ownBank,
  input  logic                 ownVal,
  input  logic                 errClr,
  output logic [NUM_BANKS-1:0] ownState,
  output logic                 errFlag
);

  localparam int WADR_W = OFF_W - 1;

  bankCmd_t [NUM_BANKS-1:0]         bankCmd;
  logic [NUM_BANKS-1:0][WADR_W-1:0] bankAddr;
  portCmd_t                         hostCmd, cpuCmd;
  logic [BANK_W-1:0]                hostBankSel, cpuBankSel;

  sbb_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_BYTES (BANK_BYTES),
    .RESET_OWNER(RESET_OWNER)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostMode   (hostMode),
    .hostAddr   (hostAddr),
    .cpuSel     (cpuSel),
    .cpuWr      (cpuWr),
    .cpuAddr    (cpuAddr),
    .cpuBe      (cpuBe),
    .ownWr      (ownWr),
    .ownBank    (ownBank),
    .ownVal     (ownVal),
    .errClr     (errClr),
    .bankCmd    (bankCmd),
    .bankAddr   (bankAddr),
    .hostCmd    (hostCmd),
    .hostBankSel(hostBankSel),
    .cpuCmd     (cpuCmd),
    .cpuBankSel (cpuBankSel),
    .ownState   (ownState),
    .errFlag    (errFlag)
  );

  sbb_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_BYTES(BANK_BYTES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .bankCmd    (bankCmd),
    .bankAddr   (bankAddr),
    .hostCmd    (hostCmd),
    .hostBankSel(hostBankSel),
    .cpuCmd     (cpuCmd),
    .cpuBankSel (cpuBankSel),
    .hostWdata  (hostWdata),
    .cpuWdata   (cpuWdata),
    .hostRdata  (hostRdata),
    .cpuRdata   (cpuRdata)
  );

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int                   NUM_BANKS   = 2,
  parameter int                   BANK_BYTES  = 1024,
  parameter logic [NUM_BANKS-1:0] RESET_OWNER = 2'b10,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = OFF_W + BANK_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostSel,
  input logic                 hostWr,
  input logic [1:0]           hostMode,
  input logic [ADDR_W-1:0]    hostAddr,
  input logic [15:0]          hostRdata,
  input logic                 cpuSel,
  input logic                 cpuWr,
  input logic [ADDR_W-1:1]    cpuAddr,
  input logic [15:0]          cpuRdata,
  input logic                 errClr,
  input logic [NUM_BANKS-1:0] ownState,
  input logic                 errFlag
);

  logic              hostOnC;
  logic [BANK_W-1:0] hb, cb;

  assign hostOnC = (hostMode == 2'b01) || (hostMode == 2'b10);
  assign hb      = hostAddr[ADDR_W-1:OFF_W];
  assign cb      = cpuAddr[ADDR_W-1:OFF_W];

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rstN) |-> (!errFlag && ownState == RESET_OWNER));

  // R6
  a_r6_cpu_foreign_ones: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWr && !ownState[cb]) |=> (cpuRdata == 16'hFFFF));

  // R6
  a_r6_host_foreign_ones: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr && hostOnC && ownState[hb]) |=> (hostRdata == 16'hFFFF && errFlag));

  // R7
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  // R10
  a_r10_off_ones: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr && !hostOnC) |=> (hostRdata == 16'hFFFF));

  // R10
  a_r10_off_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && hostSel && !hostOnC && !cpuSel) |=> !errFlag);

  // R11
  a_r11_conflict_flag: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostOnC && cpuSel && hb == cb) |=> errFlag);

  // R9
  a_r9_host_no_switch: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostOnC) |=> (ownState[$past(hb)] == $past(ownState[hb])));

  // R9
  a_r9_cpu_no_switch: assert property (@(posedge clk) disable iff (!rstN)
    cpuSel |=> (ownState[$past(cb)] == $past(ownState[cb])));

endmodule

bind shared_bank_buf sbb_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .BANK_BYTES (BANK_BYTES),
  .RESET_OWNER(RESET_OWNER)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .hostSel  (hostSel),
  .hostWr   (hostWr),
  .hostMode (hostMode),
  .hostAddr (hostAddr),
  .hostRdata(hostRdata),
  .cpuSel   (cpuSel),
  .cpuWr    (cpuWr),
  .cpuAddr  (cpuAddr),
  .cpuRdata (cpuRdata),
  .errClr   (errClr),
  .ownState (ownState),
  .errFlag  (errFlag)
);

// File: tb/shared_bank_buf_tb_top.sv
module shared_bank_buf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] M_OFF = 2'b00, M_BYTE = 2'b01, M_WORD = 2'b10, M_OFF2 = 2'b11;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostSel, hostWr;
  logic [1:0]  hostMode;
  logic [10:0] hostAddr;
  logic [15:0] hostWdata, hostRdata;
  logic        cpuSel, cpuWr;
  logic [10:1] cpuAddr;
  logic [1:0]  cpuBe;
  logic [15:0] cpuWdata, cpuRdata;
  logic        ownWr, ownBank, ownVal, errClr;
  logic [1:0]  ownState;
  logic        errFlag;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bank_buf dut_i (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostMode(hostMode), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuBe(cpuBe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .ownWr(ownWr), .ownBank(ownBank), .ownVal(ownVal), .errClr(errClr),
    .ownState(ownState), .errFlag(errFlag)
  );

  task automatic idle();
    hostSel = 0; hostWr = 0; hostMode = M_WORD; hostAddr = '0; hostWdata = '0;
    cpuSel = 0; cpuWr = 0; cpuAddr = '0; cpuBe = '0; cpuWdata = '0;
    ownWr = 0; ownBank = 0; ownVal = 0; errClr = 0;
  endtask

  // Inputs are set just after a falling edge; hold across one rising edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setHost(logic [1:0] mode, logic wr, int addr, logic [15:0] data);
    hostSel = 1; hostMode = mode; hostWr = wr; hostAddr = 11'(addr); hostWdata = data;
  endtask

  task automatic setCpu(logic wr, int addr, logic [1:0] be, logic [15:0] data);
    cpuSel = 1; cpuWr = wr; cpuAddr = addr[10:1]; cpuBe = be; cpuWdata = data;
  endtask

  task automatic hostOp(logic [1:0] mode, logic wr, int addr, logic [15:0] data);
    setHost(mode, wr, addr, data); tick();
  endtask

  task automatic cpuOp(logic wr, int addr, logic [1:0] be, logic [15:0] data);
    setCpu(wr, addr, be, data); tick();
  endtask

  task automatic setOwner(logic bank, logic val);
    ownWr = 1; ownBank = bank; ownVal = val; tick();
  endtask

  task automatic clearErr();
    errClr = 1; tick();
  endtask

  task automatic t_reset();
    check("R1 ownState", {14'd0, ownState}, 16'h0002);
    check("R1 errFlag", {15'd0, errFlag}, 16'h0000);
    check("R1 hostRdata", hostRdata, 16'h0000);
    check("R1 cpuRdata", cpuRdata, 16'h0000);
  endtask

  task automatic t_hostWord();
    hostOp(M_WORD, 1, 'h004, 16'hA5C3);
    hostOp(M_WORD, 1, 'h3FE, 16'h1234);
    hostOp(M_WORD, 0, 'h005, 16'h0);   // odd address bit ignored
    check("R2 word read", hostRdata, 16'hA5C3);
    hostOp(M_WORD, 0, 'h3FE, 16'h0);
    check("R2 last word of bank", hostRdata, 16'h1234);
  endtask

  task automatic t_hostByte();
    hostOp(M_BYTE, 1, 'h010, 16'hEE11);
    hostOp(M_BYTE, 1, 'h011, 16'hDD22);
    hostOp(M_WORD, 0, 'h010, 16'h0);
    check("R3 lanes merged", hostRdata, 16'h2211);
    hostOp(M_BYTE, 0, 'h011, 16'h0);
    check("R3 odd byte read", hostRdata, 16'h0022);
    hostOp(M_BYTE, 0, 'h010, 16'h0);
    check("R3 even byte read", hostRdata, 16'h0011);
  endtask

  task automatic t_cpuStrobes();
    cpuOp(1, 'h408, 2'b11, 16'hBEEF);
    cpuOp(1, 'h408, 2'b01, 16'h0077);
    cpuOp(1, 'h408, 2'b10, 16'h55AA);
    cpuOp(0, 'h408, 2'b00, 16'h0);
    check("R4 byte enables", cpuRdata, 16'h5577);
  endtask

  task automatic t_parallel();
    setHost(M_WORD, 1, 'h020, 16'hCAFE);
    setCpu(1, 'h420, 2'b11, 16'hF00D);
    tick();
    setHost(M_WORD, 0, 'h020, 16'h0);
    setCpu(0, 'h420, 2'b11, 16'h0);
    tick();
    check("R5 host side", hostRdata, 16'hCAFE);
    check("R5 cpu side", cpuRdata, 16'hF00D);
    check("R5 no error", {15'd0, errFlag}, 16'h0000);
  endtask

  task automatic t_foreign();
    hostOp(M_WORD, 1, 'h420, 16'h1111);
    check("R6 err on foreign write", {15'd0, errFlag}, 16'h0001);
    cpuOp(0, 'h420, 2'b11, 16'h0);
    check("R6 foreign write ignored", cpuRdata, 16'hF00D);
    hostOp(M_WORD, 0, 'h420, 16'h0);
    check("R6 host foreign read", hostRdata, 16'hFFFF);
    cpuOp(0, 'h020, 2'b11, 16'h0);
    check("R6 cpu foreign read", cpuRdata, 16'hFFFF);
  endtask

  task automatic t_sticky();
    tick(); tick();
    check("R7 flag holds", {15'd0, errFlag}, 16'h0001);
    clearErr();
    check("R7 flag cleared", {15'd0, errFlag}, 16'h0000);
    errClr = 1;
    setCpu(0, 'h000, 2'b11, 16'h0);
    tick();
    check("R7 set wins over clear", {15'd0, errFlag}, 16'h0001);
    clearErr();
  endtask

  task automatic t_contend();
    setHost(M_WORD, 1, 'h030, 16'hAAAA);
    setCpu(1, 'h030, 2'b11, 16'hBBBB);
    tick();
    check("R11 contention flagged", {15'd0, errFlag}, 16'h0001);
    hostOp(M_WORD, 0, 'h030, 16'h0);
    check("R11 owner write kept", hostRdata, 16'hAAAA);
    clearErr();
  endtask

  task automatic t_handover();
    setOwner(0, 1);
    check("R8 bank0 to cpu", {14'd0, ownState}, 16'h0003);
    cpuOp(0, 'h030, 2'b11, 16'h0);
    check("R8 cpu sees host data", cpuRdata, 16'hAAAA);
    hostOp(M_WORD, 0, 'h030, 16'h0);
    check("R8 host now refused", hostRdata, 16'hFFFF);
    clearErr();
    setOwner(1, 0);
    check("R8 bank1 to host", {14'd0, ownState}, 16'h0001);
    hostOp(M_WORD, 0, 'h420, 16'h0);
    check("R8 host sees cpu data", hostRdata, 16'hF00D);
  endtask

  task automatic t_deferred();
    ownWr = 1; ownBank = 1; ownVal = 1;
    setHost(M_WORD, 1, 'h422, 16'h7E57);
    tick();
    check("R9 change held during access", {14'd0, ownState}, 16'h0001);
    check("R9 access ran under old owner", {15'd0, errFlag}, 16'h0000);
    tick();
    check("R9 change applied when idle", {14'd0, ownState}, 16'h0003);
    cpuOp(0, 'h422, 2'b11, 16'h0);
    check("R9 write landed", cpuRdata, 16'h7E57);
  endtask

  task automatic t_disabled();
    setOwner(0, 0);
    hostOp(M_WORD, 1, 'h040, 16'h1357);
    hostOp(M_OFF, 1, 'h040, 16'h9999);
    hostOp(M_OFF2, 1, 'h040, 16'h8888);
    hostOp(M_OFF, 0, 'h040, 16'h0);
    check("R10 off read ones", hostRdata, 16'hFFFF);
    hostOp(M_WORD, 0, 'h040, 16'h0);
    hostOp(M_OFF2, 0, 'h040, 16'h0);
    check("R10 alt off read ones", hostRdata, 16'hFFFF);
    check("R10 no error", {15'd0, errFlag}, 16'h0000);
    hostOp(M_WORD, 0, 'h040, 16'h0);
    check("R10 writes ignored", hostRdata, 16'h1357);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_hostWord();
    t_hostByte();
    t_cpuStrobes();
    t_parallel();
    t_foreign();
    t_sticky();
    t_contend();
    t_handover();
    t_deferred();
    t_disabled();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule